// File: doc/BRIEF.md
# Four-Bit Status-Flag ALU

This block is a purely combinational arithmetic-logic unit. It takes two operands and a three-bit operation code, and it returns a result word together with four status bits: carry, sign, overflow and zero. The operand width is a parameter with a default of four bits. All behaviour and encodings described below assume that default.

The unit offers three bitwise operations: AND, XOR, and inversion of the first operand. It also offers three arithmetic operations: addition, subtraction, and decrement of the first operand. All three arithmetic operations run through one shared adder, which is fed by an operand selector.

The lowest code bit does not matter for decrement or for addition, so each of those operations occupies two code points. Every operation updates all four flags. The bitwise operations force carry and overflow low.

Top module: `alu4_flag_unit`

## Requirements
- R1: Code 3'b000 gives `result = a_in & b_in`, with flag_c = 0 and flag_v = 0.
- R2: Code 3'b001 gives `result = a_in - b_in`, computed as a_in + ~b_in + 1. flag_c is the adder carry out of the top bit, so it is 1 exactly when a_in >= b_in taken as unsigned. flag_v is 1 when the operands differ in sign and the result sign differs from a_in.
- R3: Codes 3'b010 and 3'b011 both give `result = a_in - 1`, computed as a_in + 4'b1111. flag_c is 1 unless a_in is 0. flag_v is 1 only when a_in = 4'b1000. The lowest code bit has no effect.
- R4: Code 3'b100 gives `result = ~a_in`, with flag_c = 0 and flag_v = 0. b_in has no effect.
- R5: Code 3'b101 gives `result = a_in ^ b_in`, with flag_c = 0 and flag_v = 0.
- R6: Codes 3'b110 and 3'b111 both give `result = a_in + b_in`. flag_c is the carry out of bit 3. flag_v is 1 when both operands have the same sign and the result sign differs. The lowest code bit has no effect.
- R7: flag_s always equals bit 3 of result.
- R8: flag_z is 1 exactly when all bits of result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 4 | First operand |
| b_in | input | 4 | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | 4 | Operation result |
| flag_c | output | 1 | Carry out of the top bit (arithmetic only) |
| flag_s | output | 1 | Sign, copy of the top result bit |
| flag_v | output | 1 | Two's-complement overflow (arithmetic only) |
| flag_z | output | 1 | Result is all zeros |

## Verification
Every pair of operands is applied under all eight codes. This exposes any decode fault, including a lowest code bit that wrongly matters. It also catches any wrong carry or overflow term at the wrap points.

Directed cases then target the points that set the arithmetic variants apart:
- decrement of 0 and of 4'b1000;
- subtraction with equal operands and with a borrow;
- addition of 4'b0111 and 4'b0001.

Seeded random vectors follow the directed cases. A further check applies inversion under two different b_in values to show that b_in is ignored.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
   typedef enum logic [2:0] {
      K_AND = 3'd0,
      K_SUB = 3'd1,
      K_DEC = 3'd2,
      K_NOT = 3'd3,
      K_XOR = 3'd4,
      K_ADD = 3'd5
   } op_kind_t;
endpackage

// File: rtl/alu4_decode.sv
module alu4_decode
   import alu4_pkg::*;
(
   input  logic [2:0] code,
   output op_kind_t   kind,
   output logic       is_arith
);
   always_comb begin
      unique casez (code)
         3'b000:  kind = K_AND;
         3'b001:  kind = K_SUB;
         3'b01?:  kind = K_DEC;
         3'b100:  kind = K_NOT;
         3'b101:  kind = K_XOR;
         default: kind = K_ADD;
      endcase
      is_arith = (kind == K_SUB) || (kind == K_DEC) || (kind == K_ADD);
   end
endmodule

// File: rtl/alu4_arith.sv
module alu4_arith
   import alu4_pkg::*;
#(
   parameter int WIDTH  = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  op_kind_t         kind,
   output logic [WIDTH-1:0] sum,
   output logic             carry,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic             cin;

   always_comb begin
      case (kind)
         K_SUB:   begin b_eff = ~b;              cin = 1'b1; end
         K_DEC:   begin b_eff = {WIDTH{1'b1}};   cin = 1'b0; end
         default: begin b_eff = b;               cin = 1'b0; end
      endcase
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cc;
         assign cc[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b_eff[i] ^ cc[i];
            assign cc[i+1] = (a[i] & b_eff[i]) | (cc[i] & (a[i] ^ b_eff[i]));
         end
         assign carry = cc[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
         assign sum   = wide[WIDTH-1:0];
         assign carry = wide[WIDTH];
      end
   endgenerate

   assign ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic
   import alu4_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  op_kind_t         kind,
   output logic [WIDTH-1:0] out
);
   always_comb begin
      case (kind)
         K_AND:   out = a & b;
         K_XOR:   out = a ^ b;
         K_NOT:   out = ~a;
         default: out = '0;
      endcase
   end
endmodule

// File: rtl/alu4_flag_unit.sv
module alu4_flag_unit
   import alu4_pkg::*;
#(
   parameter int WIDTH  = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [2:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             flag_c,
   output logic             flag_s,
   output logic             flag_v,
   output logic             flag_z
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu4_flag_unit: WIDTH must be at least 2");
      end
   endgenerate

   op_kind_t         kind;
   logic             is_arith;
   logic [WIDTH-1:0] sum, lout;
   logic             carry, ovf;

   alu4_decode u_dec (.code(op_sel), .kind(kind), .is_arith(is_arith));

   alu4_arith #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_arith (
      .a(a_in), .b(b_in), .kind(kind), .sum(sum), .carry(carry), .ovf(ovf)
   );

   alu4_logic #(.WIDTH(WIDTH)) u_logic (
      .a(a_in), .b(b_in), .kind(kind), .out(lout)
   );

   always_comb begin
      result = is_arith ? sum : lout;
      flag_c = is_arith & carry;
      flag_v = is_arith & ovf;
      flag_s = result[MSB];
      flag_z = ~|result;
   end
endmodule

// File: rtl/alu4_flag_unit_chk.sv
module alu4_flag_unit_chk #(
   parameter int WIDTH = 4
) (
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic [2:0]       op_sel,
   input logic [WIDTH-1:0] result,
   input logic             flag_c,
   input logic             flag_s,
   input logic             flag_v,
   input logic             flag_z
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      a_r7_sign: assert (flag_s == result[MSB]);
      a_r8_zero: assert (flag_z == (result == '0));
      if (op_sel == 3'b000 || op_sel == 3'b100 || op_sel == 3'b101)
         a_r1_r4_r5_no_cv: assert (!flag_c && !flag_v);
      if (op_sel[2:1] == 2'b01)
         a_r3_dec_overflow: assert (flag_v == (a_in == {1'b1, {(WIDTH-1){1'b0}}}));
      if (op_sel == 3'b001)
         a_r2_sub_carry: assert (flag_c == (a_in >= b_in));
      if (op_sel[2:1] == 2'b11)
         a_r6_add_overflow: assert (flag_v ==
            ((a_in[MSB] == b_in[MSB]) && (result[MSB] != a_in[MSB])));
   end
endmodule

bind alu4_flag_unit alu4_flag_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu4_flag_unit.sv
module tb_alu4_flag_unit;
   logic       clk = 1'b0;
   logic [3:0] a_in, b_in, result;
   logic [2:0] op_sel;
   logic       flag_c, flag_s, flag_v, flag_z;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   alu4_flag_unit dut (.*);

   // returns {c, s, v, z, res[3:0]}
   function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b,
                                        input logic [2:0] op);
      int ai, bi, r;
      logic [3:0] res;
      logic c, v;
      ai = int'(a); bi = int'(b); c = 1'b0; v = 1'b0;
      case (op)
         3'b000: res = a & b;
         3'b100: res = ~a;
         3'b101: res = a ^ b;
         3'b001: begin
            r = ai - bi; res = r[3:0]; c = (ai >= bi);
            v = (a[3] != b[3]) && (res[3] != a[3]);
         end
         3'b010, 3'b011: begin
            r = ai + 15; res = r[3:0]; c = (ai != 0); v = (a == 4'b1000);
         end
         default: begin
            r = ai + bi; res = r[3:0]; c = (r > 15);
            v = (a[3] == b[3]) && (res[3] != a[3]);
         end
      endcase
      return {c, res[3], v, (res == 4'd0), res};
   endfunction

   function automatic string tag(input logic [2:0] op);
      case (op)
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010, 3'b011: return "R3";
         3'b100: return "R4";
         3'b101: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [2:0] op);
      logic [7:0] exp, got;
      @(posedge clk);
      a_in = a; b_in = b; op_sel = op;
      @(negedge clk);
      exp = model(a, b, op);
      got = {flag_c, flag_s, flag_v, flag_z, result};
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s (flags R7 R8) a=%h b=%h op=%b actual=%b expected=%b",
                  tag(op), a, b, op, got, exp);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0] r0, r1;
      void'($urandom(32'h5eed_0042));
      a_in = '0; b_in = '0; op_sel = '0;
      // initial state: AND of zeros gives zero result, Z set (R1, R8)
      apply(4'h0, 4'h0, 3'b000);
      // directed corners
      apply(4'h0, 4'h0, 3'b010);   // R3 decrement of 0: C=0
      apply(4'h8, 4'h0, 3'b011);   // R3 decrement of 1000: V=1
      apply(4'h5, 4'h5, 3'b001);   // R2 equal: Z=1, C=1
      apply(4'h3, 4'h7, 3'b001);   // R2 borrow: C=0
      apply(4'h8, 4'h1, 3'b001);   // R2 overflow
      apply(4'h7, 4'h1, 3'b110);   // R6 overflow
      apply(4'hF, 4'h1, 3'b111);   // R6 carry, zero
      apply(4'hA, 4'h5, 3'b101);   // R5
      // R4: b_in ignored, outputs compared across two b values
      apply(4'h6, 4'h0, 3'b100);
      r0 = result;
      apply(4'h6, 4'hF, 3'b100);
      r1 = result;
      checks++;
      if (r0 != r1) begin
         errors++;
         $display("FAIL R4 b_in affected result actual=%h expected=%h", r1, r0);
      end
      // exhaustive sweep over all codes, covering R1..R8
      for (int op = 0; op < 8; op++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               apply(4'(a), 4'(b), 3'(op));
      // seeded random vectors
      for (int k = 0; k < 200; k++)
         apply(4'($urandom), 4'($urandom), 3'($urandom));
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule